// File: doc/BRIEF.md
# Running Monobit Health Monitor

This block watches a random bitstream one bit at a time and raises a flag when the balance of ones and zeros drifts too far. Each accepted bit counts as +1 for a one and -1 for a zero. The block keeps the signed running total of these values and the number of bits accepted since the last clear.

An unbiased source keeps the total inside a three-sigma envelope, which grows with the square root of the bit count. The block tests this without a square root: it compares the squared total with nine times the count. The check is held off until a parameterized minimum count is reached, so that short records cannot raise a false alarm. Once the alarm is set it stays set until clear.

The counter saturates rather than wrapping, so very long records are safe. A system can sample the alarm at any time as a health indication for the entropy source. It can read the total and the count to log how far the source has drifted.

Top module: `monobit_monitor`

## Requirements
- R1: When `valid_in` is high and `clear_in` is low, a one on `bit_in` adds 1 to `sum_o` and a zero subtracts 1. `count_o` grows by 1. Both outputs show the new values after the next rising clock edge.
- R2: With `valid_in` low and `clear_in` low, `sum_o`, `count_o` and `alarm_o` keep their values, whatever `bit_in` does.
- R3: `clear_in` high zeroes `sum_o`, `count_o` and `alarm_o` at the next edge. It wins over a simultaneous `valid_in`, and the bit presented with it is discarded.
- R4: After an accepted bit, `alarm_o` is set at that same edge when the updated count is at least MIN_N and the square of the updated sum is greater than or equal to 9 times the updated count. Equality sets the alarm.
- R5: While `count_o` is below MIN_N, `alarm_o` stays low, however unbalanced the bits are.
- R6: Once set, `alarm_o` stays high until `clear_in`, even if later bits bring the sum back inside the envelope.
- R7: `count_o` stops at 2^CNT_W-1. Bits offered after that are ignored: `sum_o` and `count_o` both hold.
- R8: While `rst_n` is low, the outputs are all zero.
- R9: `sum_o` is two's complement and CNT_W+1 bits wide. Its magnitude never exceeds `count_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_in | input | 1 | Bit under test |
| valid_in | input | 1 | `bit_in` is accepted at this edge |
| clear_in | input | 1 | Synchronous restart of the statistic |
| alarm_o | output | 1 | Sticky envelope violation flag |
| sum_o | output | CNT_W+1 | Signed running total of the +1/-1 values |
| count_o | output | CNT_W | Number of accepted bits, saturating |

## Verification
The assertions assume that `clear_in` and `valid_in` are known, synchronous levels after reset. They also assume that `bit_in` matters only at edges where `valid_in` is high. The bench drives every input only at falling edges and gives each one a definite value from the first cycle. It deliberately toggles `bit_in` while `valid_in` is low, and raises `clear_in` together with `valid_in`, so that the assumed priorities are exercised. It also runs one record past the counter limit, so that the saturation properties see the clamped state.

// File: rtl/mm_pkg.sv
package mm_pkg;
   localparam int unsigned NINE_SHIFT = 3;
   localparam int unsigned NINE_EXTRA = 4;

   function automatic int unsigned sum_width(input int unsigned cnt_w);
      return cnt_w + 1;
   endfunction
endpackage

// File: rtl/mm_accum.sv
module mm_accum #(
   parameter int unsigned CNT_W = 32,
   localparam int unsigned SUM_W = mm_pkg::sum_width(CNT_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_in,
   input  logic             valid_in,
   input  logic             bit_in,
   output logic [SUM_W-1:0] sum_q,
   output logic [CNT_W-1:0] cnt_q,
   output logic [SUM_W-1:0] sum_d,
   output logic [CNT_W-1:0] cnt_d,
   output logic             upd_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [SUM_W-1:0] ONE_S   = {{(SUM_W-1){1'b0}}, 1'b1};
   localparam logic [CNT_W-1:0] ONE_C   = {{(CNT_W-1){1'b0}}, 1'b1};

   always_comb begin
      upd_o = valid_in && !clear_in && (cnt_q != CNT_MAX);
      sum_d = sum_q;
      cnt_d = cnt_q;
      if (upd_o) begin
         sum_d = bit_in ? (sum_q + ONE_S) : (sum_q - ONE_S);
         cnt_d = cnt_q + ONE_C;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_q <= '0;
         cnt_q <= '0;
      end else if (clear_in) begin
         sum_q <= '0;
         cnt_q <= '0;
      end else begin
         sum_q <= sum_d;
         cnt_q <= cnt_d;
      end
   end
endmodule

// File: rtl/mm_envelope.sv
module mm_envelope #(
   parameter int unsigned CNT_W = 32,
   parameter int unsigned MIN_N = 64,
   localparam int unsigned SUM_W = mm_pkg::sum_width(CNT_W),
   localparam int unsigned SQ_W  = 2 * SUM_W,
   localparam int unsigned N9_W  = CNT_W + mm_pkg::NINE_EXTRA
) (
   input  logic [SUM_W-1:0] sum_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic             hit_o
);
   logic [SUM_W-1:0] mag;
   logic [SQ_W-1:0]  sq;
   logic [N9_W-1:0]  nine_n;
   logic             outside;
   logic             armed;

   always_comb begin
      mag     = sum_i[SUM_W-1] ? (~sum_i + {{(SUM_W-1){1'b0}}, 1'b1}) : sum_i;
      sq      = {{SUM_W{1'b0}}, mag} * {{SUM_W{1'b0}}, mag};
      nine_n  = {{mm_pkg::NINE_EXTRA{1'b0}}, cnt_i}
              + {1'b0, cnt_i, {mm_pkg::NINE_SHIFT{1'b0}}};
      outside = (sq >= {{(SQ_W-N9_W){1'b0}}, nine_n});
   end

   generate
      if (MIN_N <= 1) begin : g_no_gate
         assign armed = 1'b1;
      end else begin : g_gate
         localparam logic [CNT_W-1:0] MIN_L = CNT_W'(MIN_N);
         assign armed = (cnt_i >= MIN_L);
      end
   endgenerate

   assign hit_o = armed && outside;
endmodule

// File: rtl/mm_alarm.sv
module mm_alarm (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_in,
   input  logic upd_i,
   input  logic hit_i,
   output logic alarm_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              alarm_q <= 1'b0;
      else if (clear_in)       alarm_q <= 1'b0;
      else if (upd_i && hit_i) alarm_q <= 1'b1;
   end
endmodule

// File: rtl/monobit_monitor.sv
module monobit_monitor #(
   parameter int unsigned CNT_W = 32,
   parameter int unsigned MIN_N = 64
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bit_in,
   input  logic                       valid_in,
   input  logic                       clear_in,
   output logic                       alarm_o,
   output logic signed [CNT_W:0]      sum_o,
   output logic        [CNT_W-1:0]    count_o
);
   localparam int unsigned SUM_W = mm_pkg::sum_width(CNT_W);

   generate
      if (CNT_W < 2 || CNT_W > 62) begin : g_bad_width
         $error("monobit_monitor: CNT_W out of range");
      end
      if (CNT_W < 32 && MIN_N >= (64'd1 << CNT_W)) begin : g_bad_min
         $error("monobit_monitor: MIN_N not reachable by counter");
      end
   endgenerate

   logic [SUM_W-1:0] sum_q, sum_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             upd, hit;

   mm_accum #(.CNT_W(CNT_W)) u_accum (
      .clk(clk), .rst_n(rst_n), .clear_in(clear_in), .valid_in(valid_in),
      .bit_in(bit_in), .sum_q(sum_q), .cnt_q(cnt_q), .sum_d(sum_d),
      .cnt_d(cnt_d), .upd_o(upd)
   );

   mm_envelope #(.CNT_W(CNT_W), .MIN_N(MIN_N)) u_env (
      .sum_i(sum_d), .cnt_i(cnt_d), .hit_o(hit)
   );

   mm_alarm u_alarm (
      .clk(clk), .rst_n(rst_n), .clear_in(clear_in), .upd_i(upd),
      .hit_i(hit), .alarm_q(alarm_o)
   );

   assign sum_o   = $signed(sum_q);
   assign count_o = cnt_q;
endmodule

// File: rtl/mm_checker.sv
module mm_checker #(
   parameter int unsigned CNT_W = 32,
   parameter int unsigned MIN_N = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bit_in,
   input logic             valid_in,
   input logic             clear_in,
   input logic             alarm_o,
   input logic [CNT_W:0]   sum_o,
   input logic [CNT_W-1:0] count_o
);
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
   localparam logic [CNT_W:0]   ONE  = {{CNT_W{1'b0}}, 1'b1};
   logic [CNT_W:0] mag;
   logic           below_min;

   always_comb begin
      mag       = sum_o[CNT_W] ? (~sum_o + ONE) : sum_o;
      below_min = ({32'd0, count_o} < 64'(MIN_N));
   end

   AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && !clear_in && bit_in && count_o != CMAX) |=> (sum_o == $past(sum_o) + ONE)); // R1
   AST_STEP_DN: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && !clear_in && !bit_in && count_o != CMAX) |=> (sum_o == $past(sum_o) - ONE)); // R1
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_in && !clear_in) |=> ($stable(sum_o) && $stable(count_o) && $stable(alarm_o))); // R2
   AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clear_in |=> (sum_o == '0 && count_o == '0 && !alarm_o)); // R3
   AST_ALARM_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm_o) |-> ($past(valid_in) && !$past(clear_in))); // R4
   AST_MIN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      below_min |-> !alarm_o); // R5
   AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_o && !clear_in) |=> alarm_o); // R6
   AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
      (count_o == CMAX && !clear_in) |=> (count_o == CMAX && $stable(sum_o))); // R7
   AST_SUM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (mag <= {1'b0, count_o})); // R9
endmodule

bind monobit_monitor mm_checker #(.CNT_W(CNT_W), .MIN_N(MIN_N)) u_chk (
   .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .valid_in(valid_in),
   .clear_in(clear_in), .alarm_o(alarm_o), .sum_o(sum_o), .count_o(count_o)
);

// File: tb/monobit_monitor_tb_top.sv
module monobit_monitor_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int CW   = 10;
   localparam int MINN = 16;
   localparam int CMAX = (1 << CW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_in = 1'b0, valid_in = 1'b0, clear_in = 1'b0;
   logic alarm_o;
   logic signed [CW:0] sum_o;
   logic [CW-1:0] count_o;

   int n_chk = 0, n_bad = 0;
   int m_sum = 0, m_cnt = 0;
   bit m_al = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   monobit_monitor #(.CNT_W(CW), .MIN_N(MINN)) dut_i (
      .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .valid_in(valid_in),
      .clear_in(clear_in), .alarm_o(alarm_o), .sum_o(sum_o), .count_o(count_o)
   );

   // stimulus {clear, valid, bit} and expected {alarm, sum, count}
   typedef struct packed { bit c; bit v; bit b; bit al; int s; int n; } vec_t;
   localparam vec_t VECS [12] = '{
      '{1,0,0, 0, 0,0},  // R3
      '{0,1,1, 0, 1,1},  // R1
      '{0,1,1, 0, 2,2},  // R1
      '{0,1,0, 0, 1,3},  // R1
      '{0,0,1, 0, 1,3},  // R2 bit toggled, not valid
      '{0,1,0, 0, 0,4},  // R1
      '{0,1,0, 0,-1,5},  // R1
      '{0,1,0, 0,-2,6},  // R1
      '{0,1,0, 0,-3,7},  // R1
      '{1,1,1, 0, 0,0},  // R3 clear beats valid
      '{0,1,1, 0, 1,1},  // R1
      '{0,1,0, 0, 0,2}   // R1
   };

   task automatic check(string req, bit eal, int es, int en);
      n_chk++;
      if (alarm_o !== eal || int'(sum_o) != es || int'(count_o) != en) begin
         n_bad++;
         $display("FAIL %s: got alarm=%0d sum=%0d count=%0d, expected alarm=%0d sum=%0d count=%0d",
                  req, alarm_o, int'(sum_o), int'(count_o), eal, es, en);
      end
   endtask

   // drive at falling edge, sample at the following falling edge
   task automatic step(bit c, bit v, bit b);
      clear_in = c; valid_in = v; bit_in = b;
      if (c) begin m_sum = 0; m_cnt = 0; m_al = 0; end
      else if (v && m_cnt < CMAX) begin
         m_sum += b ? 1 : -1;
         m_cnt += 1;
         if (m_cnt >= MINN && m_sum * m_sum >= 9 * m_cnt) m_al = 1;
      end
      @(negedge clk);
   endtask

   task automatic run(string req, bit c, bit v, bit b);
      step(c, v, b);
      check(req, m_al, m_sum, m_cnt);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      check("R8", 0, 0, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8", 0, 0, 0);

      foreach (VECS[i]) begin
         step(VECS[i].c, VECS[i].v, VECS[i].b);
         check("R1/R2/R3 table", VECS[i].al, VECS[i].s, VECS[i].n);
      end

      // all ones: gate holds below MIN_N, alarm at MIN_N
      run("R3", 1, 0, 0);
      for (int k = 0; k < MINN - 1; k++) run("R5", 0, 1, 1);
      check("R5", 0, MINN - 1, MINN - 1);
      run("R4", 0, 1, 1);
      check("R4", 1, MINN, MINN);
      // return toward balance: alarm sticks
      for (int k = 0; k < 20; k++) run("R6", 0, 1, k[0]);
      check("R6", 1, m_sum, m_cnt);
      run("R6", 0, 0, 0);
      run("R3", 1, 1, 0);

      // all zeros, negative sum
      for (int k = 0; k < MINN; k++) run("R4", 0, 1, 0);
      check("R4", 1, -MINN, MINN);
      run("R3", 1, 0, 0);

      // equality: n=16, S=12 (2 zeros then 14 ones) sets alarm
      run("R4", 0, 1, 0); run("R4", 0, 1, 0);
      for (int k = 0; k < 13; k++) run("R4", 0, 1, 1);
      check("R4", 0, 11, 15);
      run("R4", 0, 1, 1);
      check("R4", 1, 12, 16);
      run("R3", 1, 0, 0);

      // just inside: n=16, S=10 (3 zeros, 13 ones) then S=12 at n=18
      for (int k = 0; k < 3; k++) run("R4", 0, 1, 0);
      for (int k = 0; k < 13; k++) run("R4", 0, 1, 1);
      check("R4", 0, 10, 16);
      run("R4", 0, 1, 1);
      run("R4", 0, 1, 1);
      check("R4", 0, 12, 18);
      for (int k = 0; k < 4; k++) run("R2", 0, 0, k[0]);
      check("R2", 0, 12, 18);
      run("R3", 1, 0, 0);

      // saturation with alternating bits
      for (int k = 0; k < CMAX + 6; k++) run("R7", 0, 1, ~k[0]);
      check("R7", 0, 1, CMAX);
      run("R7", 0, 1, 1);
      run("R7", 0, 1, 0);
      check("R7", 0, 1, CMAX);
      run("R3", 1, 0, 0);
      check("R9", 0, 0, 0);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule